// File: doc/BRIEF.md
# Chain conversion readback sequencer

This block drives the SPI link to a daisy chain of battery monitor devices (one master plus up to seven slaves). One `start` pulse runs a complete measurement. The block sends two broadcast command frames: the first points the read pointer at the first cell register, the second requests a conversion of all inputs with all results read back, triggered by chip select. It then holds chip select high for the worst-case conversion time and clocks out one 32-bit result frame per channel of every device.

Each returned frame has its CRC checked. A good frame is passed out on a one-cycle result strobe. Its 12-bit code is added to a running cell-voltage total when its channel number names a cell rather than an auxiliary input. The sequence ends with a `done` pulse. If any frame carries a bad CRC, the sequence ends at once with an `err` pulse. The conversion wait is derived in hardware from the chain length, the averaging code and the acquisition-time code, all sampled when the start is accepted.

Top module: `chain_readback_seq`

## Requirements
- R1: The first frame after an accepted start is a broadcast write of data 0x00 to register 0x1C. A write frame has these fields:
  - bits 31:27: device address, 0
  - bits 26:21: register
  - bits 20:13: data
  - bit 12: broadcast flag, 1
  - bit 11: 0
  - bits 10:3: CRC of bits 31:11
  - bits 2:0: 010

  The CRC works as follows. Let g(b) shift a byte left eight times, XOR-ing 0x2F each time a one leaves bit 7. For a value v zero-padded to 24 bits, the CRC is g(g(v[23:16]) ^ v[15:8]) ^ v[7:0].
- R2: The second frame is a broadcast write to register 0x0D with data 0x08 | (avg_sel << 1).
- R3: Exactly (slaves+1)×12 readback frames follow, each sending 0xF800030A on MOSI.
- R4: Between the second frame and the first readback frame, chip select stays high for exactly W×CLK_PER_US clock cycles. W is computed as follows:
  - Let t be 465, 1010, 1460 or 1890 for acq_sel 0 to 3.
  - Let n be 2^avg_sel.
  - Then W = ceil(((t+695)·12·n − t + slaves·250)/1000) + 5.
- R5: The link runs in SPI mode 1:
  - SCLK is low whenever chip select is high.
  - MOSI changes only on a rising SCLK edge, MSB first.
  - MISO is sampled on falling edges.
  - Each SCLK half period lasts HALF clock cycles.
  - Outside the conversion wait, chip select stays high for GAP cycles between frames.
- R6: Every readback frame whose bits 9:2 equal the CRC of its bits 31:10 is presented, whole, on `res_frame` with a one-cycle `res_valid`. Frames appear in arrival order.
- R7: `cell_sum` is cleared at start. It accumulates bits 22:11 of each good frame whose channel field (bits 26:23) is 0 to 5. Channels 6 to 11 are not added.
- R8: On a CRC mismatch the block pulses `err`, emits no result for that frame, starts no further frame and returns to idle.
- R9: `done` pulses one cycle after the last `res_valid` and never together with `err`. After reset, chip select is high, SCLK is low and all strobes are low.
- R10: `start` is ignored while a sequence runs. The chain length and codes are taken only at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| start | input | 1 | Begin a sequence when idle |
| slaves | input | SLV_W | Number of slave devices after the master |
| acq_sel | input | 2 | Acquisition-time code |
| avg_sel | input | 2 | Averaging code |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to the chain |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_miso | input | 1 | SPI data from the chain |
| res_valid | output | 1 | One-cycle strobe for a good readback frame |
| res_frame | output | 32 | The readback frame |
| cell_sum | output | SUM_W | Running total of cell-channel codes |
| done | output | 1 | Sequence completed |
| err | output | 1 | Sequence aborted on a CRC error |

## Verification
The bench builds the block with HALF=1, GAP=2, CLK_PER_US=2 and MAX_DEV=8. These values make a frame about 66 cycles long and cap the longest wait near 500 cycles. That keeps every one of the 128 combinations of chain length, acquisition code and averaging code within reach for the wait and command-frame checks. The bench aborts each of those runs on a corrupted first readback frame. It also runs full chains of every length to exhaustion, with varying data, and checks the total and every result frame. It adds a mid-chain CRC error and a start pulse with changed settings during a running sequence.

// File: rtl/chain_readback_seq.sv
module chain_readback_seq #(
  parameter int MAX_DEV    = 8,
  parameter int HALF       = 89,
  parameter int GAP        = 16,
  parameter int CLK_PER_US = 125,
  parameter int SLV_W      = $clog2(MAX_DEV),
  parameter int SUM_W      = $clog2(MAX_DEV * 6 * 4095 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SLV_W-1:0] slaves,
  input  logic [1:0]       acq_sel,
  input  logic [1:0]       avg_sel,
  output logic             spi_sclk,
  output logic             spi_mosi,
  output logic             spi_cs_n,
  input  logic             spi_miso,
  output logic             res_valid,
  output logic [31:0]      res_frame,
  output logic [SUM_W-1:0] cell_sum,
  output logic             done,
  output logic             err
);

  function automatic int wait_us(input int acq, input int avg, input int slv);
    int t;
    int num;
    case (acq)
      0: t = 465;
      1: t = 1010;
      2: t = 1460;
      default: t = 1890;
    endcase
    num = (t + 695) * 12 * (1 << avg) - t + slv * 250;
    return (num + 999) / 1000 + 5;
  endfunction

  function automatic logic [7:0] crc_shift(input logic [7:0] b);
    logic [7:0] c;
    c = b;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'h2F) : (c << 1);
    return c;
  endfunction

  function automatic logic [7:0] crc24(input logic [23:0] v);
    return crc_shift(crc_shift(v[23:16]) ^ v[15:8]) ^ v[7:0];
  endfunction

  function automatic logic [31:0] wr_frame(input logic [5:0] rg, input logic [7:0] d);
    logic [31:0] w;
    w = {5'd0, rg, d, 1'b1, 12'd0};
    w[10:3] = crc24({3'd0, w[31:11]});
    w[2:0] = 3'b010;
    return w;
  endfunction

  localparam int FW       = 32;
  localparam int BW       = $clog2(FW + 1);
  localparam int PH_W     = $clog2(HALF + 1);
  localparam int RD_W     = $clog2(MAX_DEV * 12 + 1);
  localparam int MAX_WAIT = wait_us(3, 3, MAX_DEV - 1) * CLK_PER_US + GAP;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [31:0] NOOP      = 32'hF800_030A;
  localparam logic [5:0]  REG_RDPTR = 6'h1C;
  localparam logic [5:0]  REG_CTRLH = 6'h0D;

  typedef enum logic [1:0] {IDLE, XFER, HOLD, FIN} state_t;
  typedef enum logic [1:0] {F_PTR, F_CTRL, F_READ} step_t;

  state_t           state;
  step_t            step;
  logic [PH_W-1:0]  ph;
  logic [BW-1:0]    bitn;
  logic [CNT_W-1:0] cnt;
  logic [RD_W-1:0]  rdn;
  logic [31:0]      rx;
  logic [SLV_W-1:0] slv_q;
  logic [1:0]       acq_q, avg_q;

  logic [31:0]      tx_word;
  logic [RD_W-1:0]  rd_total;
  logic             rx_ok;

  assign tx_word  = (step == F_PTR)  ? wr_frame(REG_RDPTR, 8'h00) :
                    (step == F_CTRL) ? wr_frame(REG_CTRLH, {4'b0000, 1'b1, avg_q, 1'b0}) : NOOP;
  assign rd_total = RD_W'((int'(slv_q) + 1) * 12);
  assign rx_ok    = (crc24({2'b00, rx[31:10]}) == rx[9:2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      step      <= F_PTR;
      ph        <= '0;
      bitn      <= '0;
      cnt       <= '0;
      rdn       <= '0;
      rx        <= '0;
      slv_q     <= '0;
      acq_q     <= '0;
      avg_q     <= '0;
      spi_sclk  <= 1'b0;
      spi_mosi  <= 1'b0;
      spi_cs_n  <= 1'b1;
      res_valid <= 1'b0;
      res_frame <= '0;
      cell_sum  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      case (state)
        IDLE: if (start) begin
          slv_q    <= slaves;
          acq_q    <= acq_sel;
          avg_q    <= avg_sel;
          step     <= F_PTR;
          rdn      <= '0;
          cell_sum <= '0;
          spi_cs_n <= 1'b0;
          ph       <= PH_W'(HALF - 1);
          bitn     <= '0;
          state    <= XFER;
        end
        XFER: if (ph != '0) begin
          ph <= ph - 1'b1;
        end else begin
          ph <= PH_W'(HALF - 1);
          if (spi_sclk) begin
            spi_sclk <= 1'b0;
            rx       <= {rx[30:0], spi_miso};
            bitn     <= bitn + 1'b1;
          end else if (bitn != BW'(FW)) begin
            spi_sclk <= 1'b1;
            spi_mosi <= tx_word[5'd31 - bitn[4:0]];
          end else begin
            spi_cs_n <= 1'b1;
            state    <= HOLD;
            case (step)
              F_PTR: begin
                step <= F_CTRL;
                cnt  <= CNT_W'(GAP - 1);
              end
              F_CTRL: begin
                step <= F_READ;
                cnt  <= CNT_W'(wait_us(int'(acq_q), int'(avg_q), int'(slv_q)) * CLK_PER_US - 1);
              end
              default: begin
                if (!rx_ok) begin
                  err   <= 1'b1;
                  state <= IDLE;
                end else begin
                  res_valid <= 1'b1;
                  res_frame <= rx;
                  if (rx[26:23] <= 4'd5) cell_sum <= cell_sum + SUM_W'(rx[22:11]);
                  rdn <= rdn + 1'b1;
                  cnt <= CNT_W'(GAP - 1);
                  if (rdn + 1'b1 == rd_total) state <= FIN;
                end
              end
            endcase
          end
        end
        HOLD: if (cnt == '0) begin
          spi_cs_n <= 1'b0;
          ph       <= PH_W'(HALF - 1);
          bitn     <= '0;
          state    <= XFER;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: begin
          done  <= 1'b1;
          state <= IDLE;
        end
      endcase
    end
  end

  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  p_mosi_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(spi_sclk) |-> $stable(spi_mosi));
  p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HOLD) |-> (spi_cs_n && !spi_sclk));
  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (state == IDLE && spi_cs_n && !res_valid));
  p_done_after_res_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(res_valid));
  p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  p_res_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (rdn <= rd_total));

endmodule

// File: tb/chain_readback_seq_test.sv
`timescale 1ns/100ps
module chain_readback_seq_test;
  localparam int MAX_DEV = 8;
  localparam int HALF = 1;
  localparam int GAP = 2;
  localparam int CPU = 2;
  localparam int SUM_W = $clog2(MAX_DEV * 6 * 4095 + 1);
  localparam logic [31:0] NOOP = 32'hF800_030A;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] slaves = '0;
  logic [1:0] acq_sel = '0, avg_sel = '0;
  logic spi_sclk, spi_mosi, spi_cs_n;
  logic spi_miso = 1'b0;
  logic res_valid, done, err;
  logic [31:0] res_frame;
  logic [SUM_W-1:0] cell_sum;

  chain_readback_seq #(.MAX_DEV(MAX_DEV), .HALF(HALF), .GAP(GAP), .CLK_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .slaves(slaves), .acq_sel(acq_sel),
    .avg_sel(avg_sel), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
    .spi_miso(spi_miso), .res_valid(res_valid), .res_frame(res_frame),
    .cell_sum(cell_sum), .done(done), .err(err));

  initial forever #4 clk = ~clk;

  int nvec = 0, nbad = 0;
  int fidx = 0, rcnt = 0, rmis = 0, bad_k = -1, seed = 0;
  logic [31:0] cap [0:127];
  int gapc [0:127];
  time t_rise = 0;

  function automatic logic [7:0] g8(input logic [7:0] b);
    logic [7:0] c = b;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'h2F) : (c << 1);
    return c;
  endfunction
  function automatic logic [7:0] crc(input logic [23:0] v);
    return g8(g8(v[23:16]) ^ v[15:8]) ^ v[7:0];
  endfunction
  function automatic logic [31:0] wcmd(input logic [5:0] rg, input logic [7:0] d);
    logic [31:0] w = {5'd0, rg, d, 1'b1, 12'd0};
    w[10:3] = crc({3'd0, w[31:11]});
    w[2:0] = 3'b010;
    return w;
  endfunction
  function automatic logic [11:0] code(input int k, input int s);
    return 12'((k * 373 + s * 97 + 5) % 4096);
  endfunction
  function automatic logic [31:0] resp(input int k, input int s, input bit bad);
    logic [31:0] f = {5'(k / 12), 4'(k % 12), code(k, s), 1'b0, 8'h00, 2'b00};
    f[9:2] = crc({2'b00, f[31:10]});
    if (bad) f[9:2] = f[9:2] ^ 8'h01;
    return f;
  endfunction
  function automatic int exp_wait(input int acq, input int avg, input int slv);
    int t = (acq == 0) ? 465 : (acq == 1) ? 1010 : (acq == 2) ? 1460 : 1890;
    int num = (t + 695) * 12 * (1 << avg) - t + slv * 250;
    return ((num + 999) / 1000 + 5) * CPU;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // chain model: MISO driven on rising SCLK, MOSI captured on falling SCLK
  initial forever begin
    logic [31:0] r, sh;
    int k;
    @(negedge spi_cs_n);
    gapc[fidx] = int'(($time - t_rise) / 8);
    k = fidx - 2;
    r = (fidx >= 2) ? resp(k, seed, k == bad_k) : 32'h0;
    sh = '0;
    for (int i = 0; i < 32; i++) begin
      @(posedge spi_sclk) spi_miso = r[31 - i];
      @(negedge spi_sclk) sh = {sh[30:0], spi_mosi};
    end
    cap[fidx] = sh;
    fidx++;
    @(posedge spi_cs_n) t_rise = $time;
  end

  initial forever begin
    @(negedge clk);
    if (res_valid) begin
      if (res_frame != resp(rcnt, seed, 1'b0)) rmis++;
      rcnt++;
    end
  end

  task automatic run(input int slv, input int acq, input int avg, input int badk, input bit poke);
    int n = 0, total = (slv + 1) * 12, expsum = 0;
    bit got_done = 0, got_err = 0;
    logic [SUM_W-1:0] sum_at_done = '0;
    fidx = 0; rcnt = 0; rmis = 0; bad_k = badk; seed++;
    @(negedge clk);
    slaves = 3'(slv); acq_sel = 2'(acq); avg_sel = 2'(avg); start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      slaves = 3'(slv + 3); acq_sel = 2'(acq + 1); avg_sel = 2'(avg + 2); start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!got_done && !got_err && n < 20000) begin
      @(negedge clk);
      n++;
      if (done) begin got_done = 1; sum_at_done = cell_sum; end
      if (err) got_err = 1;
    end
    chk(n < 20000, "watchdog", n, 20000);
    repeat (20) @(negedge clk);
    chk(cap[0] == wcmd(6'h1C, 8'h00), "R1", cap[0], wcmd(6'h1C, 8'h00));
    chk(cap[1] == wcmd(6'h0D, {4'b0000, 1'b1, 2'(avg), 1'b0}), "R2", cap[1],
        wcmd(6'h0D, {4'b0000, 1'b1, 2'(avg), 1'b0}));
    chk(gapc[1] == GAP, "R5", gapc[1], GAP);
    chk(gapc[2] == exp_wait(acq, avg, slv), "R4", gapc[2], exp_wait(acq, avg, slv));
    if (badk < 0) begin
      int nm = 0;
      for (int k = 0; k < total; k++) begin
        if (cap[k + 2] != NOOP) nm++;
        if (k % 12 < 6) expsum += int'(code(k, seed));
      end
      chk(fidx == 2 + total, "R3 frame count R10", fidx, 2 + total);
      chk(nm == 0, "R3 noop words", nm, 0);
      chk(rcnt == total && rmis == 0, "R6", rcnt * 1000 + rmis, total * 1000);
      chk(got_done && !got_err, "R9", {got_done, got_err}, 2'b10);
      chk(int'(sum_at_done) == expsum, "R7", sum_at_done, expsum);
    end else begin
      chk(got_err && !got_done, "R8 flags", {got_err, got_done}, 2'b10);
      chk(fidx == 3 + badk, "R8 no further frame", fidx, 3 + badk);
      chk(rcnt == badk && rmis == 0, "R6 R8 results", rcnt * 1000 + rmis, badk * 1000);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R5 reset pins", {spi_cs_n, spi_sclk}, 2'b10);
    chk(done === 1'b0 && err === 1'b0 && res_valid === 1'b0, "R9 reset strobes",
        {done, err, res_valid}, 3'b000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int s = 0; s < MAX_DEV; s++) run(s, s % 4, (s / 2) % 4, -1, 1'b0);
    for (int s = 0; s < MAX_DEV; s++)
      for (int a = 0; a < 4; a++)
        for (int v = 0; v < 4; v++) run(s, a, v, 0, 1'b0);
    run(3, 1, 2, 17, 1'b0);
    run(2, 3, 1, 35, 1'b0);
    run(1, 2, 0, -1, 1'b1);
    run(4, 0, 3, -1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule